// File: doc/BRIEF.md
# Streaming Packet Framing Error Detector

This block sits beside a valid/ready stream whose beats carry start-of-packet and end-of-packet flags. A packet is expected to be a group of `CHANS` beats. The first beat is channel 0 and the last is channel `CHANS-1`. A beat is taken only in a cycle where valid and ready are both high. The block tracks whether a packet is open and which channel slot the next beat fills.

The block returns each taken beat one cycle later, with its data, its channel slot and a 2-bit framing code. After a violation the block does not stop. It restarts its tracking so that the stream resynchronises on the offending beat.

The code values are:

| Code | Meaning |
|------|---------|
| `00` | clean beat |
| `01` | the start flag was absent where a packet had to begin |
| `10` | a new start arrived while a packet was still open |
| `11` | an end flag was misplaced, or any other framing fault |

Top module: `frame_err_detect`

## Requirements
- R1: A beat is taken only when `in_valid` and `in_ready` are both high. In any other cycle, `out_valid` is low one cycle later and `pkt_open` keeps its value.
- R2: Synchronous active-high reset. One cycle after `rst` is seen high, `pkt_open` is 0, `out_valid` is 0 and `out_err` is 00.
- R3: Each taken beat appears one cycle later on the outputs:
  - `out_valid` is high;
  - `out_data` equals the beat's data;
  - `out_chan` holds the beat's channel slot, where 0 is the first slot of a group.
- R4: Consider a packet whose start flag is on slot 0 and whose end flag is on slot `CHANS-1`, with neither flag on the beats between. Every beat of it gets code 00. `pkt_open` is 1 after each beat except the last, and 0 after the last.
- R5: A taken beat with no packet open and the start flag low gets code 01. It is treated as slot 0 of a newly opened packet.
- R6: A taken beat with the start flag high while a packet is open gets code 10. It is treated as slot 0 of a new packet.
- R7: Code 11 is given to an end flag on any slot other than `CHANS-1`. It is also given to an end flag with no packet open and no start flag. Any taken end flag closes the packet.
- R8: A slot `CHANS-1` beat without the end flag gets code 11. The packet stays open and the next beat fills slot 0.
- R9: When the condition for code 11 coincides with that of code 10 or code 01, the beat gets code 11.
- R10: `out_err` is 00 whenever `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream beat valid |
| in_ready | input | 1 | Downstream ready for the beat |
| in_sop | input | 1 | Start-of-packet flag of the beat |
| in_eop | input | 1 | End-of-packet flag of the beat |
| in_data | input | DATA_W | Beat payload |
| out_valid | output | 1 | Registered beat valid |
| out_data | output | DATA_W | Registered beat payload |
| out_chan | output | CW | Channel slot the beat occupied |
| out_err | output | 2 | Framing code (00, 01, 10, 11) |
| pkt_open | output | 1 | A packet is currently open |

## Verification
Two checks can hit the same beat. The misplaced-end check can coincide with either the early-start check or the missing-start check.

The bench provokes the first pairing with one beat that carries both start and end flags while a packet is open. It provokes the second pairing with a lone end-flag beat while no packet is open. In both cases the expected code is 11, and the packet must be closed afterwards.

The bench also interleaves stalled cycles, where valid is high and ready is low, inside an open packet. This confirms that no slot is consumed by those cycles.

// File: rtl/frame_chk_pkg.sv
package frame_chk_pkg;

    typedef enum logic [1:0] {
        FRM_OK      = 2'b00,
        FRM_NO_SOP  = 2'b01,
        FRM_NO_EOP  = 2'b10,
        FRM_BAD_EOP = 2'b11
    } frm_err_e;

    // Decide the code for one taken beat.
    // was_open : a packet was open before the beat
    // at_last  : the beat lands on the final slot of the group
    function automatic frm_err_e frm_classify(
        input logic was_open,
        input logic sop,
        input logic eop,
        input logic at_last
    );
        logic bad_end;
        bad_end = eop ? (!at_last || (!was_open && !sop)) : at_last;
        if (bad_end)
            return FRM_BAD_EOP;
        else if (was_open && sop)
            return FRM_NO_EOP;
        else if (!was_open && !sop)
            return FRM_NO_SOP;
        else
            return FRM_OK;
    endfunction

endpackage

// File: rtl/frm_slot_tracker.sv
module frm_slot_tracker #(
    parameter int CHANS = 4,
    parameter int CW    = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic          sop,
    input  logic          eop,
    output logic          open_q,
    output logic [CW-1:0] slot_eff,
    output logic          at_last
);
    localparam logic [CW-1:0] LAST_SLOT = CW'(CHANS - 1);

    logic [CW-1:0] slot_q;

    // A start flag or a closed packet restarts the group at slot 0.
    always_comb begin
        slot_eff = (sop || !open_q) ? '0 : slot_q;
        at_last  = (slot_eff == LAST_SLOT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            slot_q <= '0;
        end else if (fire) begin
            if (eop) begin
                open_q <= 1'b0;
                slot_q <= '0;
            end else begin
                open_q <= 1'b1;
                slot_q <= at_last ? '0 : slot_eff + 1'b1;
            end
        end
    end

endmodule

// File: rtl/frm_err_classify.sv
module frm_err_classify
    import frame_chk_pkg::*;
(
    input  logic     fire,
    input  logic     was_open,
    input  logic     sop,
    input  logic     eop,
    input  logic     at_last,
    output frm_err_e code
);
    always_comb begin
        code = fire ? frm_classify(was_open, sop, eop, at_last) : FRM_OK;
    end

endmodule

// File: rtl/frm_out_stage.sv
module frm_out_stage
    import frame_chk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CW     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [DATA_W-1:0] data_in,
    input  logic [CW-1:0]     slot_in,
    input  frm_err_e          code_in,
    output logic              vld_q,
    output logic [DATA_W-1:0] data_q,
    output logic [CW-1:0]     slot_q,
    output frm_err_e          code_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            data_q <= '0;
            slot_q <= '0;
            code_q <= FRM_OK;
        end else begin
            vld_q  <= fire;
            code_q <= fire ? code_in : FRM_OK;
            if (fire) begin
                data_q <= data_in;
                slot_q <= slot_in;
            end
        end
    end

endmodule

// File: rtl/frame_err_detect.sv
module frame_err_detect
    import frame_chk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CHANS  = 4,
    localparam int CW    = (CHANS > 1) ? $clog2(CHANS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_ready,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [CW-1:0]     out_chan,
    output logic [1:0]        out_err,
    output logic              pkt_open
);
    logic          fire;
    logic          open_q;
    logic [CW-1:0] slot_eff;
    logic          at_last;
    frm_err_e      code;
    frm_err_e      code_q;

    assign fire = in_valid && in_ready;

    frm_slot_tracker #(.CHANS(CHANS), .CW(CW)) u_track (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .sop      (in_sop),
        .eop      (in_eop),
        .open_q   (open_q),
        .slot_eff (slot_eff),
        .at_last  (at_last)
    );

    frm_err_classify u_class (
        .fire     (fire),
        .was_open (open_q),
        .sop      (in_sop),
        .eop      (in_eop),
        .at_last  (at_last),
        .code     (code)
    );

    frm_out_stage #(.DATA_W(DATA_W), .CW(CW)) u_out (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .data_in (in_data),
        .slot_in (slot_eff),
        .code_in (code),
        .vld_q   (out_valid),
        .data_q  (out_data),
        .slot_q  (out_chan),
        .code_q  (code_q)
    );

    assign out_err  = code_q;
    assign pkt_open = open_q;

endmodule

// File: rtl/frame_err_detect_chk.sv
module frame_err_detect_chk #(
    parameter int CHANS = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic       in_sop,
    input logic       in_eop,
    input logic       out_valid,
    input logic [1:0] out_err,
    input logic       pkt_open
);
    logic fire;
    assign fire = in_valid && in_ready;

    a_r2_reset_clears: assert property (@(posedge clk)
        rst |=> (!pkt_open && !out_valid && out_err == 2'b00));

    a_r1_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !fire |=> (!out_valid && $stable(pkt_open)));

    a_r10_idle_code_zero: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_err == 2'b00));

    a_r5_missing_start: assert property (@(posedge clk) disable iff (rst)
        (CHANS > 1 && fire && !pkt_open && !in_sop && !in_eop)
        |=> (out_err == 2'b01 && pkt_open));

    a_r6_early_start: assert property (@(posedge clk) disable iff (rst)
        (CHANS > 1 && fire && pkt_open && in_sop && !in_eop)
        |=> (out_err == 2'b10 && pkt_open));

    a_r7_end_closes: assert property (@(posedge clk) disable iff (rst)
        (fire && in_eop) |=> !pkt_open);

    a_r7_stray_end: assert property (@(posedge clk) disable iff (rst)
        (fire && in_eop && !in_sop && !pkt_open) |=> (out_err == 2'b11));

endmodule

bind frame_err_detect frame_err_detect_chk #(.CHANS(CHANS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .out_valid (out_valid),
    .out_err   (out_err),
    .pkt_open  (pkt_open)
);

// File: tb/frame_err_detect_bench.sv
module frame_err_detect_bench;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready = 1'b0;
    logic          in_sop = 1'b0;
    logic          in_eop = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic [1:0]    out_chan;
    logic [1:0]    out_err;
    logic          pkt_open;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;
    logic [DW-1:0] dseq = 16'hA000;

    typedef struct {
        logic [DW-1:0] d;
        logic [1:0]    ch;
        logic [1:0]    er;
        logic          op;
        string         req;
    } exp_t;

    exp_t q[$];

    always #2.5 clk = ~clk;

    frame_err_detect #(.DATA_W(DW), .CHANS(4)) u_frame_err_detect (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_chan  (out_chan),
        .out_err   (out_err),
        .pkt_open  (pkt_open)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops expected beats as the design produces them.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R3", "unexpected out_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(out_data == e.d, "R3", "data", out_data, e.d);
                    check(out_chan == e.ch, e.req, "chan", out_chan, e.ch);
                    check(out_err == e.er, e.req, "err", out_err, e.er);
                    check(pkt_open == e.op, e.req, "pkt_open", pkt_open, e.op);
                end
            end else begin
                check(out_err == 2'b00, "R10", "err while idle", out_err, 0);
            end
        end
    end

    // Driver: one taken beat plus its expected result.
    task automatic beat(input logic s, input logic e, input logic [1:0] ch,
                        input logic [1:0] er, input logic op, input string req);
        exp_t x;
        @(negedge clk);
        in_valid = 1'b1;
        in_ready = 1'b1;
        in_sop   = s;
        in_eop   = e;
        in_data  = dseq;
        x.d = dseq; x.ch = ch; x.er = er; x.op = op; x.req = req;
        q.push_back(x);
        dseq = dseq + 16'h0111;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // R1: valid without ready, carrying flags that would otherwise act.
    task automatic stall(input logic s, input logic e, input logic exp_open);
        @(negedge clk);
        in_valid = 1'b1;
        in_ready = 1'b0;
        in_sop   = s;
        in_eop   = e;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid on stall", out_valid, 0);
        check(pkt_open == exp_open, "R1", "pkt_open on stall", pkt_open, exp_open);
        in_valid = 1'b0;
        in_ready = 1'b1;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(pkt_open == 1'b0, "R2", "pkt_open in reset", pkt_open, 0);
        check(out_valid == 1'b0, "R2", "out_valid in reset", out_valid, 0);
        check(out_err == 2'b00, "R2", "out_err in reset", out_err, 0);
        rst = 1'b0;

        // R4 clean packet
        beat(1, 0, 2'd0, 2'b00, 1, "R4");
        beat(0, 0, 2'd1, 2'b00, 1, "R4");
        beat(0, 0, 2'd2, 2'b00, 1, "R4");
        beat(0, 1, 2'd3, 2'b00, 0, "R4");
        idle(2);

        // R5 missing start
        beat(0, 0, 2'd0, 2'b01, 1, "R5");
        beat(0, 0, 2'd1, 2'b00, 1, "R5");
        beat(0, 0, 2'd2, 2'b00, 1, "R5");
        beat(0, 1, 2'd3, 2'b00, 0, "R5");
        idle(2);

        // R6 start while open, with R1 stall inside the packet
        beat(1, 0, 2'd0, 2'b00, 1, "R6");
        stall(0, 1, 1'b1);
        beat(0, 0, 2'd1, 2'b00, 1, "R6");
        beat(1, 0, 2'd0, 2'b10, 1, "R6");
        beat(0, 0, 2'd1, 2'b00, 1, "R6");
        beat(0, 0, 2'd2, 2'b00, 1, "R6");
        beat(0, 1, 2'd3, 2'b00, 0, "R6");
        idle(2);

        // R1 stall while closed with a start flag
        stall(1, 0, 1'b0);
        idle(1);

        // R7 early end
        beat(1, 0, 2'd0, 2'b00, 1, "R7");
        beat(0, 1, 2'd1, 2'b11, 0, "R7");
        // R7/R9 stray end with no packet open and no start
        beat(0, 1, 2'd0, 2'b11, 0, "R9");
        idle(2);

        // R8 last slot without end flag
        beat(1, 0, 2'd0, 2'b00, 1, "R8");
        beat(0, 0, 2'd1, 2'b00, 1, "R8");
        beat(0, 0, 2'd2, 2'b00, 1, "R8");
        beat(0, 0, 2'd3, 2'b11, 1, "R8");
        beat(0, 0, 2'd0, 2'b00, 1, "R8");
        beat(0, 0, 2'd1, 2'b00, 1, "R8");
        beat(0, 0, 2'd2, 2'b00, 1, "R8");
        beat(0, 1, 2'd3, 2'b00, 0, "R8");
        idle(2);

        // R9 start+end while open: 11 wins over 10
        beat(1, 0, 2'd0, 2'b00, 1, "R9");
        beat(1, 1, 2'd0, 2'b11, 0, "R9");
        idle(2);

        // R2 reset mid-packet
        beat(1, 0, 2'd0, 2'b00, 1, "R2");
        idle(1);
        rst = 1'b1;
        @(negedge clk);
        check(pkt_open == 1'b0, "R2", "pkt_open after reset", pkt_open, 0);
        check(out_valid == 1'b0, "R2", "out_valid after reset", out_valid, 0);
        rst = 1'b0;
        // the next beat must be judged against a closed packet
        beat(0, 0, 2'd0, 2'b01, 1, "R2");
        idle(3);

        check(q.size() == 0, "R3", "outstanding beats", q.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule